// File: doc/BRIEF.md
# Binary-Point Preemption CPU Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor presents its most urgent candidate: an interrupt ID, an 8-bit priority and a group bit. The block decides whether that candidate should be signalled now. Group 0 candidates are signalled on the fast request line and group 1 candidates on the normal request line. A lower priority number means a more urgent interrupt.

A candidate must pass two tests. First, it must be more urgent than the software priority mask. Second, it must beat the interrupt that is already running. The second test uses only the preemption part of the priority. A per-group split point (the binary point) divides each priority into a preemption part and a sub-priority part. The sub-priority part never allows an interrupt to nest.

The processor acknowledges a signalled candidate to receive its ID. The processor ends the interrupt with an end-of-interrupt pulse. The block keeps a stack of active preemption priorities, so interrupts can nest to a parameterised depth. The top of that stack is presented as the running priority.

Top module: `bp_cpu_iface`

## Requirements
- R1: For group 0, a split value N acts as max(N, MIN_BP). For N from 0 to 6, priority bits [7:N+1] form the preemption part and the lower bits are dropped.
- R2: A group 0 split value of 7 stops any group 0 candidate from being signalled while the active stack is not empty. When the stack is empty, such a candidate is still signalled.
- R3: For group 1, a split value N acts as max(N, MIN_BP+1), so a value of 0 is never used as written. Bits [7:N] form the preemption part.
- R4: Group 1 keeps only the top PRIO_BITS_B priority bits. Group 0 keeps the top PRIO_BITS_B+1 bits. The other bits are treated as zero in the mask test, in the preemption test and in the value pushed on acknowledge.
- R5: A valid candidate is pending when both of these hold:
  - its implemented priority is numerically below `prio_mask`;
  - either the stack is empty, or its preemption part is numerically below `run_prio`.
  A pending candidate raises `fiq_o` when its group is 0 and `irq_o` when its group is 1. The two lines are never high together.
- R6: An acknowledge while a candidate is pending and the stack has room does two things. In the same cycle, `ack_id` equals the candidate ID. From the next cycle, `run_prio` equals the candidate's preemption part.
- R7: An acknowledge with no pending candidate returns 1023 on `ack_id` and changes no state.
- R8: An end-of-interrupt pulse pops one stack entry. `run_prio` then returns to the previous entry, or to 0xFF when the stack becomes empty. An end-of-interrupt pulse on an empty stack has no effect.
- R9: An acknowledge of a pending candidate while DEPTH entries are active is refused:
  - `ack_id` returns 1023;
  - `run_prio` keeps its value;
  - `err_o` is high for exactly the next cycle.
- R10: When acknowledge and end-of-interrupt arrive in the same cycle, only the pop is performed and `ack_id` returns 1023.
- R11: After reset, `run_prio` is 0xFF, `err_o` is 0 and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid | input | 1 | Candidate from the distributor is valid |
| cand_id | input | ID_W | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority (lower is more urgent) |
| cand_grp | input | 1 | Candidate group (0 = fast line, 1 = normal line) |
| prio_mask | input | 8 | Priority mask threshold |
| bp_a | input | 3 | Binary point for group 0 |
| bp_b | input | 3 | Binary point for group 1 |
| ack | input | 1 | Acknowledge pulse |
| eoi | input | 1 | End-of-interrupt pulse |
| fiq_o | output | 1 | Fast interrupt request (group 0 pending) |
| irq_o | output | 1 | Normal interrupt request (group 1 pending) |
| ack_id | output | ID_W | ID returned on acknowledge, 1023 if none |
| run_prio | output | 8 | Running priority (0xFF when idle) |
| err_o | output | 1 | One-cycle pulse after a refused acknowledge |

## Verification
The bench sweeps candidates whose preemption parts lie just above, equal to and below the running priority. It repeats this under several split values, including values under the floor and the value 7. A mismatch in these runs shows where the split point is placed, or whether the floor is applied.

A second set of candidates differs only in the low, unimplemented bits, tested against a tight mask. These cases show whether each group drops the correct number of bits.

Nested acknowledges fill the stack to its depth, and end-of-interrupt pulses then unwind it past empty. These runs show the push and pop order and the refusal on a full stack. A same-cycle acknowledge and end-of-interrupt shows which of the two wins.

// File: rtl/bp_cpu_pkg.sv
package bp_cpu_pkg;

  localparam int PRIO_W = 8;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

  // Zero every bit below the top nbits of a priority.
  function automatic logic [PRIO_W-1:0] keep_top(input logic [PRIO_W-1:0] p, input int nbits);
    logic [PRIO_W-1:0] m;
    m = {PRIO_W{1'b1}} << (PRIO_W - nbits);
    return p & m;
  endfunction

  // Raise a programmed split value to the implementation floor.
  function automatic logic [2:0] floor_bp(input logic [2:0] bp, input logic [2:0] lo);
    return (bp < lo) ? lo : bp;
  endfunction

  // Preemption part: drop the lowest cut bits.
  function automatic logic [PRIO_W-1:0] preempt_part(input logic [PRIO_W-1:0] p, input int cut);
    return keep_top(p, PRIO_W - cut);
  endfunction

endpackage

// File: rtl/bp_prio_filter.sv
module bp_prio_filter
  import bp_cpu_pkg::*;
#(
  parameter int IMPL_BITS    = 4,
  parameter int BP_FLOOR     = 3,
  parameter int CUT_OFS      = 0,
  parameter bit SEVEN_BLOCKS = 1'b0
) (
  input  logic [PRIO_W-1:0] prio,
  input  logic [2:0]        bp,
  output logic [PRIO_W-1:0] impl,
  output logic [PRIO_W-1:0] field,
  output logic              blocked
);
  logic [2:0] bp_eff;

  always_comb begin
    bp_eff  = floor_bp(bp, 3'(BP_FLOOR));
    impl    = keep_top(prio, IMPL_BITS);
    field   = preempt_part(impl, int'(bp_eff) + CUT_OFS);
    blocked = SEVEN_BLOCKS && (bp == 3'd7);
  end
endmodule

// File: rtl/bp_active_stack.sv
module bp_active_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 top,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;

  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign top   = empty ? '1 : mem[AW'(cnt_q - 1'b1)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (pop && !empty) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (push && !full) begin
      mem[AW'(cnt_q)] <= din;
      cnt_q           <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bp_cpu_iface.sv
module bp_cpu_iface
  import bp_cpu_pkg::*;
#(
  parameter int ID_W        = 10,
  parameter int PRIO_BITS_B = 4,
  parameter int MIN_BP      = 2,
  parameter int DEPTH       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cand_valid,
  input  logic [ID_W-1:0] cand_id,
  input  logic [7:0]      cand_prio,
  input  logic            cand_grp,
  input  logic [7:0]      prio_mask,
  input  logic [2:0]      bp_a,
  input  logic [2:0]      bp_b,
  input  logic            ack,
  input  logic            eoi,
  output logic            fiq_o,
  output logic            irq_o,
  output logic [ID_W-1:0] ack_id,
  output logic [7:0]      run_prio,
  output logic            err_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [ID_W-1:0] SPUR_ID = '1;

  logic [2:0]        bp_g    [2];
  logic [PRIO_W-1:0] impl_g  [2];
  logic [PRIO_W-1:0] field_g [2];
  logic              block_g [2];

  assign bp_g[0] = bp_a;
  assign bp_g[1] = bp_b;

  for (genvar g = 0; g < 2; g++) begin : g_grp
    bp_prio_filter #(
      .IMPL_BITS    ((g == 0) ? PRIO_BITS_B + 1 : PRIO_BITS_B),
      .BP_FLOOR     ((g == 0) ? MIN_BP : MIN_BP + 1),
      .CUT_OFS      ((g == 0) ? 1 : 0),
      .SEVEN_BLOCKS (g == 0)
    ) u_filt (
      .prio    (cand_prio),
      .bp      (bp_g[g]),
      .impl    (impl_g[g]),
      .field   (field_g[g]),
      .blocked (block_g[g])
    );
  end

  // Named internal events for the checker.
  logic [PRIO_W-1:0] sel_impl, sel_field;
  logic              sel_block, below_mask, may_preempt, pending;
  logic              ack_live, grant, refuse, pop, full, empty;
  logic [CW-1:0]     depth;
  logic              err_q;

  always_comb begin
    sel_impl    = impl_g[cand_grp];
    sel_field   = field_g[cand_grp];
    sel_block   = block_g[cand_grp];
    below_mask  = sel_impl < prio_mask;
    may_preempt = empty || (!sel_block && (sel_field < run_prio));
    pending     = cand_valid && below_mask && may_preempt;
    ack_live    = ack && !eoi;
    grant       = ack_live && pending && !full;
    refuse      = ack_live && pending && full;
    pop         = eoi && !empty;
  end

  assign fiq_o  = pending && !cand_grp;
  assign irq_o  = pending &&  cand_grp;
  assign ack_id = grant ? cand_id : SPUR_ID;
  assign err_o  = err_q;

  bp_active_stack #(.DEPTH(DEPTH), .W(PRIO_W)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (grant),
    .pop   (pop),
    .din   (sel_field),
    .top   (run_prio),
    .count (depth),
    .full  (full),
    .empty (empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= refuse;
  end
endmodule

// File: rtl/bp_cpu_iface_chk.sv
module bp_cpu_iface_chk #(
  parameter int ID_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cand_valid,
  input logic            cand_grp,
  input logic [2:0]      bp_a,
  input logic            ack,
  input logic            eoi,
  input logic            fiq_o,
  input logic            irq_o,
  input logic [ID_W-1:0] ack_id,
  input logic [7:0]      run_prio,
  input logic            err_o,
  input logic            pending,
  input logic            full,
  input logic            empty,
  input logic            grant,
  input logic [7:0]      sel_field
);
  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fiq_o && irq_o));

  p_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o || irq_o) |-> cand_valid);

  p_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (run_prio == $past(sel_field)));

  p_spur_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !pending) |-> (ack_id == '1));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (run_prio == 8'hFF));

  p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !eoi && pending && full) |=> (err_o && run_prio == $past(run_prio)));

  p_eoi_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |-> (ack_id == '1));

  p_bp7_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !cand_grp && bp_a == 3'd7) |-> empty);
endmodule

bind bp_cpu_iface bp_cpu_iface_chk #(.ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cand_valid (cand_valid),
  .cand_grp   (cand_grp),
  .bp_a       (bp_a),
  .ack        (ack),
  .eoi        (eoi),
  .fiq_o      (fiq_o),
  .irq_o      (irq_o),
  .ack_id     (ack_id),
  .run_prio   (run_prio),
  .err_o      (err_o),
  .pending    (pending),
  .full       (full),
  .empty      (empty),
  .grant      (grant),
  .sel_field  (sel_field)
);

// File: tb/bp_cpu_iface_tb.sv
`timescale 1ns/1ps
module bp_cpu_iface_tb_top;
  localparam int ID_W  = 10;
  localparam int PB    = 4;
  localparam int MINBP = 2;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n;
  logic            cand_valid, cand_grp, ack, eoi;
  logic [ID_W-1:0] cand_id;
  logic [7:0]      cand_prio, prio_mask;
  logic [2:0]      bp_a, bp_b;
  logic            fiq_o, irq_o, err_o;
  logic [ID_W-1:0] ack_id;
  logic [7:0]      run_prio;

  bp_cpu_iface #(.ID_W(ID_W), .PRIO_BITS_B(PB), .MIN_BP(MINBP), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_prio(cand_prio), .cand_grp(cand_grp), .prio_mask(prio_mask),
    .bp_a(bp_a), .bp_b(bp_b), .ack(ack), .eoi(eoi), .fiq_o(fiq_o),
    .irq_o(irq_o), .ack_id(ack_id), .run_prio(run_prio), .err_o(err_o)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    stk[$];
  string cur_req = "R11";

  // Reference model: plain integer arithmetic.
  function automatic int m_impl(int p, int grp);
    int unit;
    unit = 1 << (grp ? (8 - PB) : (8 - PB - 1));
    return (p / unit) * unit;
  endfunction

  function automatic int m_field(int p, int grp, int ba, int bb);
    int sh;
    if (grp == 0) sh = ((ba < MINBP) ? MINBP : ba) + 1;
    else          sh = (bb < MINBP + 1) ? MINBP + 1 : bb;
    return (m_impl(p, grp) / (1 << sh)) * (1 << sh);
  endfunction

  function automatic int m_run();
    return (stk.size() == 0) ? 255 : stk[stk.size() - 1];
  endfunction

  function automatic bit m_pend();
    if (!cand_valid) return 1'b0;
    if (m_impl(int'(cand_prio), int'(cand_grp)) >= int'(prio_mask)) return 1'b0;
    if (stk.size() == 0) return 1'b1;
    if (!cand_grp && bp_a == 3'd7) return 1'b0;
    return m_field(int'(cand_prio), int'(cand_grp), int'(bp_a), int'(bp_b)) < m_run();
  endfunction

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  // One clock: compare combinational outputs, step the model, compare state.
  task automatic cyc();
    bit p, g, r;
    int exp_id;
    p = m_pend();
    g = ack && !eoi && p && (stk.size() < DEPTH);
    r = ack && !eoi && p && (stk.size() >= DEPTH);
    exp_id = g ? int'(cand_id) : 1023;
    #1;
    chk("fiq_o", int'(fiq_o), int'(p && !cand_grp));
    chk("irq_o", int'(irq_o), int'(p && cand_grp));
    chk("ack_id", int'(ack_id), exp_id);
    @(posedge clk);
    if (eoi && stk.size() > 0) void'(stk.pop_back());
    else if (g) stk.push_back(m_field(int'(cand_prio), int'(cand_grp), int'(bp_a), int'(bp_b)));
    #1;
    chk("run_prio", int'(run_prio), m_run());
    chk("err_o", int'(err_o), int'(r));
    @(negedge clk);
  endtask

  task automatic cand(int id, int prio, int grp);
    cand_valid = 1'b1;
    cand_id    = ID_W'(id);
    cand_prio  = 8'(prio);
    cand_grp   = grp[0];
    cyc();
  endtask

  task automatic do_ack(int id, int prio, int grp);
    ack = 1'b1;
    cand(id, prio, grp);
    ack = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    cyc();
    eoi = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cand_valid = 1'b0; cand_id = '0; cand_prio = '0; cand_grp = 1'b0;
    prio_mask = 8'hFF; bp_a = 3'd2; bp_b = 3'd3; ack = 1'b0; eoi = 1'b0;
    repeat (3) @(negedge clk);
    cur_req = "R11";
    chk("run_prio", int'(run_prio), 255);
    chk("err_o", int'(err_o), 0);
    rst_n = 1'b1;
    cyc();

    // R5: mask and line selection
    cur_req = "R5";
    prio_mask = 8'hF0;
    cand(5, 8'h40, 1);
    prio_mask = 8'h40;
    cand(5, 8'h40, 1);
    prio_mask = 8'hFF;
    cand(6, 8'h30, 0);
    cand_valid = 1'b0; cyc();

    // R6: acknowledge pushes the preemption part
    cur_req = "R6";
    do_ack(7, 8'h40, 1);

    // R1: group 0 split positions and floor
    cur_req = "R1";
    bp_a = 3'd4; cand(8, 8'h30, 0); cand(8, 8'h48, 0);
    bp_a = 3'd1; cand(8, 8'h48, 0); cand(8, 8'h38, 0);
    bp_a = 3'd6; cand(8, 8'h30, 0);

    // R2: split value 7 blocks nesting only
    cur_req = "R2";
    bp_a = 3'd7; cand(9, 8'h00, 0);
    do_eoi();
    cand(9, 8'h00, 0);
    bp_a = 3'd2;

    // R3: group 1 split positions and floor
    cur_req = "R3";
    do_ack(10, 8'h80, 1);
    bp_b = 3'd5; cand(11, 8'h70, 1); cand(11, 8'h90, 1);
    bp_b = 3'd0; cand(11, 8'h78, 1); cand(11, 8'h88, 1);
    bp_b = 3'd7; cand(11, 8'h70, 1); cand(11, 8'h90, 1);
    bp_b = 3'd3;
    do_eoi();

    // R4: unimplemented bits read as zero
    cur_req = "R4";
    prio_mask = 8'h81; cand(12, 8'h8F, 1);
    prio_mask = 8'h89; cand(12, 8'h8C, 0); cand(12, 8'h8C, 1);
    prio_mask = 8'h88; cand(12, 8'h8C, 0);
    prio_mask = 8'hFF;
    do_ack(13, 8'h8F, 1);
    cand(14, 8'h7F, 1);

    // R7: acknowledge without a pending candidate
    cur_req = "R7";
    cand_valid = 1'b0; ack = 1'b1; cyc(); ack = 1'b0;
    ack = 1'b1; cand(15, 8'hC0, 1); ack = 1'b0;

    // R8: pops, including on an empty stack
    cur_req = "R8";
    do_eoi(); do_eoi();

    // R9: fill to depth, then refuse
    cur_req = "R9";
    do_ack(20, 8'hE0, 1); do_ack(21, 8'hA0, 1);
    do_ack(22, 8'h60, 1); do_ack(23, 8'h20, 1);
    do_ack(24, 8'h00, 1);
    cand_valid = 1'b0; cyc();
    cur_req = "R8";
    for (int i = 0; i < DEPTH + 1; i++) do_eoi();

    // R10: simultaneous acknowledge and end-of-interrupt
    cur_req = "R10";
    do_ack(30, 8'h80, 1);
    ack = 1'b1; eoi = 1'b1; cand(31, 8'h40, 1); ack = 1'b0; eoi = 1'b0;
    cand(31, 8'h40, 1);

    finish_run();
  end
endmodule